// File: doc/BRIEF.md
# Branch Record Ring Buffer

This block keeps a short history of taken control-flow transfers for performance profiling. A retire stage presents one branch per cycle with its source and target addresses, a class code, the privilege of the landing point, and mispredict and transactional flags. Branches whose class or target privilege is masked off by a select register are dropped. The others go into a power-of-two circular buffer indexed by a top-of-stack pointer, which always points at the newest entry.

A call-stack mode turns the buffer into a return-address stack: calls push and near returns pop. A freeze option stops recording when the performance interrupt input fires, so that the history seen by the interrupt handler is the history at the moment of overflow. Software uses one address/data register port to read and write the select, control and pointer registers and every slot. Slots are addressed by their distance from the newest entry. A clear command wipes all slots in one cycle.

Top module: `branch_trail`

## Requirements
- R1: After reset the pointer, the select register and the control register read 0. Every slot reads 0, `frozen` is 0 and `rd_valid` is 0.
- R2: With select bit 9 clear, a kept branch first moves the pointer forward by one modulo DEPTH and then writes the entry at the new pointer. Logical entry i (0 = newest) is held in physical slot (pointer - i) mod DEPTH.
- R3: The stored source word holds the mispredict flag in bit XLEN-1, the in-transaction flag in bit XLEN-2 and the abort flag in bit XLEN-3. Source address bits XLEN-4..0 sit below them. The target is stored unchanged.
- R4: The class code selects a suppress bit in the select register: code 0 conditional uses bit 2, 1 relative call uses bit 3, 2 indirect call uses bit 4, 3 near return uses bit 5, 4 indirect jump uses bit 6, 5 relative jump uses bit 7 and 6 far branch uses bit 8. When that bit is 1 the branch is not recorded. Code 7 is never recorded.
- R5: Privilege filtering looks at the target. Select bit 0 suppresses branches whose target is ring 0 (`br_tgt_user`=0). Select bit 1 suppresses branches whose target is a less privileged ring (`br_tgt_user`=1).
- R6: With select bit 9 set, a kept call (code 1 or 2) pushes as in R2. A kept near return (code 3) moves the pointer back by one modulo DEPTH and writes nothing. No other class changes the buffer.
- R7: When control bit 0 is 1 and `pmi` is high in a cycle, `frozen` is 1 from the next cycle on. A branch in that same cycle is still recorded. While `frozen` is 1 no branch is recorded. A control write with bit 1 = 0 clears `frozen`; a write with bit 1 = 1 leaves it as it is.
- R8: While select bit 9 is set, `pmi` never sets `frozen`.
- R9: Any write to address 0x03 zeroes every source and target slot and leaves the pointer unchanged.
- R10: A read issued with `reg_rd` returns its data on `reg_rdata` with `rd_valid` high in the next cycle only. The address map is: 0x00 select (10 bits), 0x01 control {frozen, freeze enable}, 0x02 pointer, 0x40+i source word of logical entry i, 0x80+i target of logical entry i. Unmapped addresses read 0.
- R11: A write to 0x02 loads the pointer. Writes to 0x40+i and 0x80+i replace the source and target of logical entry i.
- R12: A branch presented in a cycle where `reg_wr` is high is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A retired taken branch is presented |
| br_src | input | XLEN | Branch source address |
| br_dst | input | XLEN | Branch target address |
| br_class | input | 3 | Branch class code (R4) |
| br_tgt_user | input | 1 | Target is at a less privileged ring than ring 0 |
| br_mispred | input | 1 | Branch was mispredicted |
| br_in_tx | input | 1 | Branch retired inside a transaction |
| br_abort | input | 1 | Branch is a transaction abort |
| pmi | input | 1 | Performance interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | XLEN | Register write data |
| reg_rdata | output | XLEN | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data returned this cycle |
| frozen | output | 1 | Recording is stopped by an interrupt |

## Verification
The bench builds the block with DEPTH = 8 and XLEN = 64. With that depth, ten branches wrap the pointer past the last slot, and three returns in call-stack mode drive it back through zero, so both modulo boundaries are reached early. The 64-bit width puts the flag bits in the same positions as the address bits they replace. A source address with its top bits set therefore shows whether flags and address are merged correctly.

// File: rtl/branch_trail_pkg.sv
// Shared constants for the branch record ring buffer: class codes,
// select register bit positions and the register address map.
package branch_trail_pkg;

    localparam int SEL_W      = 10;
    localparam int SEL_CS_BIT = 9;

    typedef enum logic [2:0] {
        BC_COND  = 3'd0,
        BC_RCALL = 3'd1,
        BC_ICALL = 3'd2,
        BC_RET   = 3'd3,
        BC_IJMP  = 3'd4,
        BC_RJMP  = 3'd5,
        BC_FAR   = 3'd6,
        BC_NONE  = 3'd7
    } br_class_e;

    localparam logic [7:0] ADR_SEL = 8'h00;
    localparam logic [7:0] ADR_CTL = 8'h01;
    localparam logic [7:0] ADR_TOS = 8'h02;
    localparam logic [7:0] ADR_CLR = 8'h03;
    localparam logic [1:0] PG_SRC  = 2'b01;
    localparam logic [1:0] PG_DST  = 2'b10;

endpackage

// File: rtl/bt_filter.sv
// Class and privilege filter. Purely combinational.
// It decides whether a branch survives the suppress-polarity select
// register and flags calls and near returns for call-stack mode.
// Assumes the class encoding from branch_trail_pkg.
module bt_filter
    import branch_trail_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [2:0]       cls,
    input  logic             tgt_user,
    output logic             keep,
    output logic             is_call,
    output logic             is_ret,
    output logic             cs_mode
);
    logic [3:0] cls_bit;
    logic       cls_off;
    logic       plm_off;

    // map the class code onto its suppress bit and test privilege by target
    always_comb begin
        cls_bit = {1'b0, cls} + 4'd2;
        cls_off = (cls == BC_NONE) ? 1'b1 : sel[cls_bit];
        plm_off = tgt_user ? sel[1] : sel[0];
        keep    = !cls_off && !plm_off;
        is_call = (cls == BC_RCALL) || (cls == BC_ICALL);
        is_ret  = (cls == BC_RET);
        cs_mode = sel[SEL_CS_BIT];
    end
endmodule

// File: rtl/bt_tos_ctrl.sv
// Top-of-stack pointer and freeze state.
// Decides whether a presented branch pushes, pops or is dropped.
// Assumes rec_req is already gated off in cycles with a register write.
module bt_tos_ctrl #(
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_req,
    input  logic          keep,
    input  logic          is_call,
    input  logic          is_ret,
    input  logic          cs_mode,
    input  logic          pmi,
    input  logic          frz_en,
    input  logic          ctl_wr,
    input  logic          ctl_keep,
    input  logic          tos_wr,
    input  logic [IW-1:0] tos_wdata,
    output logic [IW-1:0] tos,
    output logic          frozen,
    output logic          push,
    output logic          pop
);
    logic live;

    // a branch acts only when kept, not frozen and not blocked by a write
    always_comb begin
        live = rec_req && keep && !frozen;
        push = live && (cs_mode ? is_call : 1'b1);
        pop  = live && cs_mode && is_ret;
    end

    // pointer update: software load, then push, then pop
    always_ff @(posedge clk) begin
        if (!rst_n)      tos <= '0;
        else if (tos_wr) tos <= tos_wdata;
        else if (push)   tos <= tos + 1'b1;
        else if (pop)    tos <= tos - 1'b1;
    end

    // freeze latch: set by the interrupt outside call-stack mode, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)                              frozen <= 1'b0;
        else if (ctl_wr)                         frozen <= frozen && ctl_keep;
        else if (pmi && frz_en && !cs_mode)      frozen <= 1'b1;
    end
endmodule

// File: rtl/bt_store.sv
// Slot storage: DEPTH source words and DEPTH targets in flops.
// One recording write port and one software write port (never active
// in the same cycle), a single-cycle clear and a combinational read.
module bt_store #(
    parameter int DEPTH = 16,
    parameter int XLEN  = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            push,
    input  logic [IW-1:0]   push_idx,
    input  logic [XLEN-1:0] push_src,
    input  logic [XLEN-1:0] push_dst,
    input  logic            sw_src_wr,
    input  logic            sw_dst_wr,
    input  logic [IW-1:0]   sw_idx,
    input  logic [XLEN-1:0] sw_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_src,
    output logic [XLEN-1:0] rd_dst
);
    logic [XLEN-1:0] src_mem [DEPTH];
    logic [XLEN-1:0] dst_mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // one slot: reset or clear to zero, else take whichever write hits it
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                src_mem[g] <= '0;
                dst_mem[g] <= '0;
            end else begin
                if (push && push_idx == IW'(g)) begin
                    src_mem[g] <= push_src;
                    dst_mem[g] <= push_dst;
                end
                if (sw_src_wr && sw_idx == IW'(g)) src_mem[g] <= sw_data;
                if (sw_dst_wr && sw_idx == IW'(g)) dst_mem[g] <= sw_data;
            end
        end
    end

    // combinational read of one physical slot
    always_comb begin
        rd_src = src_mem[rd_idx];
        rd_dst = dst_mem[rd_idx];
    end
endmodule

// File: rtl/branch_trail.sv
// Branch record ring buffer top.
// Holds the select and control registers, decodes the register port,
// packs status flags into the source word and turns logical entry
// numbers into physical slots. Assumes DEPTH is 4, 8, 16 or 32 and
// XLEN is at least 8.
module branch_trail
    import branch_trail_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int XLEN  = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_valid,
    input  logic [XLEN-1:0] br_src,
    input  logic [XLEN-1:0] br_dst,
    input  logic [2:0]      br_class,
    input  logic            br_tgt_user,
    input  logic            br_mispred,
    input  logic            br_in_tx,
    input  logic            br_abort,
    input  logic            pmi,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [7:0]      reg_addr,
    input  logic [XLEN-1:0] reg_wdata,
    output logic [XLEN-1:0] reg_rdata,
    output logic            rd_valid,
    output logic            frozen
);
    logic [SEL_W-1:0] sel_q;
    logic             frz_en_q;
    logic             keep_w, is_call_w, is_ret_w, cs_mode_w;
    logic [IW-1:0]    tos_w;
    logic             push_w, pop_w;
    logic             in_rng, src_pg, dst_pg;
    logic [IW-1:0]    phys_w;
    logic [XLEN-1:0]  rd_src_w, rd_dst_w, src_word, rd_mux;

    // address decode and logical-to-physical slot mapping
    always_comb begin
        in_rng   = reg_addr[5:0] < 6'(DEPTH);
        src_pg   = (reg_addr[7:6] == PG_SRC) && in_rng;
        dst_pg   = (reg_addr[7:6] == PG_DST) && in_rng;
        phys_w   = tos_w - reg_addr[IW-1:0];
        src_word = {br_mispred, br_in_tx, br_abort, br_src[XLEN-4:0]};
    end

    // select and freeze-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            frz_en_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == ADR_SEL) sel_q    <= reg_wdata[SEL_W-1:0];
            if (reg_addr == ADR_CTL) frz_en_q <= reg_wdata[0];
        end
    end

    bt_filter u_filter (
        .sel      (sel_q),
        .cls      (br_class),
        .tgt_user (br_tgt_user),
        .keep     (keep_w),
        .is_call  (is_call_w),
        .is_ret   (is_ret_w),
        .cs_mode  (cs_mode_w)
    );

    bt_tos_ctrl #(.DEPTH(DEPTH)) u_tos (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_req   (br_valid && !reg_wr),
        .keep      (keep_w),
        .is_call   (is_call_w),
        .is_ret    (is_ret_w),
        .cs_mode   (cs_mode_w),
        .pmi       (pmi),
        .frz_en    (frz_en_q),
        .ctl_wr    (reg_wr && reg_addr == ADR_CTL),
        .ctl_keep  (reg_wdata[1]),
        .tos_wr    (reg_wr && reg_addr == ADR_TOS),
        .tos_wdata (reg_wdata[IW-1:0]),
        .tos       (tos_w),
        .frozen    (frozen),
        .push      (push_w),
        .pop       (pop_w)
    );

    bt_store #(.DEPTH(DEPTH), .XLEN(XLEN)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (reg_wr && reg_addr == ADR_CLR),
        .push      (push_w),
        .push_idx  (tos_w + 1'b1),
        .push_src  (src_word),
        .push_dst  (br_dst),
        .sw_src_wr (reg_wr && src_pg),
        .sw_dst_wr (reg_wr && dst_pg),
        .sw_idx    (phys_w),
        .sw_data   (reg_wdata),
        .rd_idx    (phys_w),
        .rd_src    (rd_src_w),
        .rd_dst    (rd_dst_w)
    );

    // read data selection
    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADR_SEL)      rd_mux = XLEN'(sel_q);
        else if (reg_addr == ADR_CTL) rd_mux = XLEN'({frozen, frz_en_q});
        else if (reg_addr == ADR_TOS) rd_mux = XLEN'(tos_w);
        else if (src_pg)              rd_mux = rd_src_w;
        else if (dst_pg)              rd_mux = rd_dst_w;
    end

    // one-cycle registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/branch_trail_chk.sv
// Assertion checker for branch_trail, attached by bind below.
// Observes the pointer, the freeze state, the filter decision and the read port.
module branch_trail_chk #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          br_valid,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [7:0]    reg_addr,
    input logic          pmi,
    input logic          keep,
    input logic          is_ret,
    input logic          cs_mode,
    input logic          frz_en,
    input logic          frozen,
    input logic [IW-1:0] tos,
    input logic          rd_valid
);
    // R2
    push_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && !reg_wr && !frozen && keep && !cs_mode |=> tos == IW'($past(tos) + 1'b1));
    // R6
    stack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid && !reg_wr && !frozen && keep && cs_mode && is_ret |=> tos == IW'($past(tos) - 1'b1));
    // R7
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !reg_wr |=> $stable(tos));
    // R7
    freeze_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pmi && frz_en && !cs_mode && !reg_wr |=> frozen);
    // R8
    no_stack_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen) |-> !$past(cs_mode));
    // R10
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> rd_valid);
    // R10
    read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !rd_valid);
    // R12
    write_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr != 8'h02 |=> $stable(tos));
endmodule

bind branch_trail branch_trail_chk #(.IW(IW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_valid (br_valid),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .pmi      (pmi),
    .keep     (keep_w),
    .is_ret   (is_ret_w),
    .cs_mode  (cs_mode_w),
    .frz_en   (frz_en_q),
    .frozen   (frozen),
    .tos      (tos_w),
    .rd_valid (rd_valid)
);

// File: tb/test_branch_trail.sv
module test_branch_trail;
    localparam int BD = 8;
    localparam int XL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_valid = 1'b0;
    logic [XL-1:0] br_src = '0, br_dst = '0;
    logic [2:0]    br_class = 3'd0;
    logic          br_tgt_user = 1'b0, br_mispred = 1'b0, br_in_tx = 1'b0, br_abort = 1'b0;
    logic          pmi = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [XL-1:0] reg_wdata = '0;
    logic [XL-1:0] reg_rdata;
    logic          rd_valid, frozen;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference state kept from the requirements
    logic [XL-1:0] m_src [BD];
    logic [XL-1:0] m_dst [BD];
    int            m_tos = 0;
    logic [9:0]    m_sel = '0;
    logic          m_fen = 1'b0, m_frz = 1'b0;

    logic [XL-1:0] exp_q [$];
    string         tag_q [$];

    always #2 clk = ~clk;

    branch_trail #(.DEPTH(BD), .XLEN(XL)) i_branch_trail (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
        .br_class(br_class), .br_tgt_user(br_tgt_user), .br_mispred(br_mispred),
        .br_in_tx(br_in_tx), .br_abort(br_abort), .pmi(pmi), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rd_valid(rd_valid), .frozen(frozen)
    );

    task automatic check(input logic [XL-1:0] act, input logic [XL-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_kept(input logic [2:0] c, input logic tu);
        if (c == 3'd7) return 1'b0;
        if (m_sel[int'(c) + 2]) return 1'b0;
        return tu ? !m_sel[1] : !m_sel[0];
    endfunction

    task automatic m_push(input logic [XL-1:0] sw, input logic [XL-1:0] d);
        m_tos = (m_tos + 1) % BD;
        m_src[m_tos] = sw;
        m_dst[m_tos] = d;
    endtask

    // driver: one branch for one cycle, reference updated per R2-R8
    task automatic drive_branch(input logic [2:0] c, input logic tu, input logic [XL-1:0] s,
                                input logic [XL-1:0] d, input logic mp, input logic tx,
                                input logic ab, input logic pm);
        logic [XL-1:0] sw;
        sw = {mp, tx, ab, s[XL-4:0]};
        br_valid = 1'b1; br_class = c; br_tgt_user = tu; br_src = s; br_dst = d;
        br_mispred = mp; br_in_tx = tx; br_abort = ab; pmi = pm;
        if (!m_frz && m_kept(c, tu)) begin
            if (!m_sel[9]) m_push(sw, d);
            else if (c == 3'd1 || c == 3'd2) m_push(sw, d);
            else if (c == 3'd3) m_tos = (m_tos + BD - 1) % BD;
        end
        if (pm && m_fen && !m_sel[9]) m_frz = 1'b1;
        @(negedge clk);
        br_valid = 1'b0; pmi = 1'b0;
    endtask

    task automatic m_write(input logic [7:0] a, input logic [XL-1:0] w);
        int i;
        i = int'(a[5:0]);
        if (a == 8'h00) m_sel = w[9:0];
        else if (a == 8'h01) begin m_fen = w[0]; m_frz = m_frz & w[1]; end
        else if (a == 8'h02) m_tos = int'(w[2:0]);
        else if (a == 8'h03) for (int k = 0; k < BD; k++) begin m_src[k] = '0; m_dst[k] = '0; end
        else if (a[7:6] == 2'b01 && i < BD) m_src[(m_tos - i + BD) % BD] = w;
        else if (a[7:6] == 2'b10 && i < BD) m_dst[(m_tos - i + BD) % BD] = w;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [XL-1:0] w);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = w;
        m_write(a, w);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // R12: branch and register write in the same cycle; the branch is dropped
    task automatic branch_with_write(input logic [7:0] a, input logic [XL-1:0] w);
        br_valid = 1'b1; br_class = 3'd5; br_tgt_user = 1'b1;
        br_src = 64'h0000_0000_00AB_0000; br_dst = 64'h0000_0000_00CD_0000;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = w;
        m_write(a, w);
        @(negedge clk);
        reg_wr = 1'b0; br_valid = 1'b0;
    endtask

    // driver side of the scoreboard: queue the expected read data, then issue the read
    task automatic reg_read(input logic [7:0] a, input string tag);
        logic [XL-1:0] e;
        int i;
        i = int'(a[5:0]);
        e = '0;
        if (a == 8'h00) e = XL'(m_sel);
        else if (a == 8'h01) e = XL'({m_frz, m_fen});
        else if (a == 8'h02) e = XL'(m_tos);
        else if (a[7:6] == 2'b01 && i < BD) e = m_src[(m_tos - i + BD) % BD];
        else if (a[7:6] == 2'b10 && i < BD) e = m_dst[(m_tos - i + BD) % BD];
        exp_q.push_back(e);
        tag_q.push_back(tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // monitor: pop and compare each returned read (R10)
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected rd_valid actual=1 expected=0");
            end else begin
                check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic read_all(input string tag);
        for (int i = 0; i < BD; i++) begin
            reg_read(8'h40 + 8'(i), $sformatf("%s src%0d", tag, i));
            reg_read(8'h80 + 8'(i), $sformatf("%s dst%0d", tag, i));
        end
    endtask

    initial begin
        for (int k = 0; k < BD; k++) begin m_src[k] = '0; m_dst[k] = '0; end
        repeat (3) @(negedge clk);
        check(XL'(rd_valid), 0, "R1 rd_valid in reset");
        check(XL'(frozen), 0, "R1 frozen in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_read(8'h00, "R1 select");
        reg_read(8'h01, "R1 control");
        reg_read(8'h02, "R1 pointer");
        read_all("R1");
        reg_read(8'h3F, "R10 unmapped");

        // R2/R3 first entries with flag packing
        drive_branch(3'd0, 1'b1, 64'h0000_0000_0040_1000, 64'h0000_0000_0040_2000, 1'b0, 1'b0, 1'b0, 1'b0);
        drive_branch(3'd1, 1'b0, 64'hFFFF_8000_0000_1234, 64'hFFFF_8000_0000_5678, 1'b1, 1'b0, 1'b1, 1'b0);
        drive_branch(3'd4, 1'b1, 64'h1FFF_0000_0000_0010, 64'h0000_0000_0000_0020, 1'b0, 1'b1, 1'b0, 1'b0);
        reg_read(8'h02, "R2 pointer after three");
        reg_read(8'h40, "R3 newest source word");
        reg_read(8'h41, "R3 flagged source word");
        reg_read(8'h81, "R3 flagged target");
        // R2 wrap past the last slot
        for (int n = 0; n < 7; n++)
            drive_branch(3'(n % 7), 1'(n % 2), 64'h0000_0000_0050_0000 + 64'(n),
                         64'h0000_0000_0060_0000 + 64'(n), 1'(n % 2), 1'b0, 1'b0, 1'b0);
        reg_read(8'h02, "R2 pointer after wrap");
        read_all("R2 wrapped");

        // R4/R5 suppression
        reg_write(8'h00, 64'h006);
        drive_branch(3'd0, 1'b0, 64'h111, 64'h222, 1'b0, 1'b0, 1'b0, 1'b0);
        reg_read(8'h02, "R4 conditional suppressed");
        drive_branch(3'd5, 1'b1, 64'h333, 64'h444, 1'b0, 1'b0, 1'b0, 1'b0);
        reg_read(8'h02, "R5 user target suppressed");
        drive_branch(3'd5, 1'b0, 64'h555, 64'h666, 1'b0, 1'b0, 1'b0, 1'b0);
        reg_read(8'h02, "R5 ring0 target kept");
        reg_read(8'h40, "R5 kept entry");
        reg_write(8'h00, 64'h0);
        drive_branch(3'd7, 1'b0, 64'h777, 64'h888, 1'b0, 1'b0, 1'b0, 1'b0);
        reg_read(8'h02, "R4 class 7 never recorded");

        // R12 branch alongside a register write
        branch_with_write(8'h00, 64'h0);
        reg_read(8'h02, "R12 branch dropped on write");

        // R9 clear
        reg_write(8'h03, 64'h1);
        reg_read(8'h02, "R9 pointer kept");
        read_all("R9 cleared");

        // R11 restore path
        reg_write(8'h02, 64'h5);
        reg_write(8'h40, 64'hDEAD_0000_0000_BEEF);
        reg_write(8'h82, 64'h0000_CAFE_0000_0001);
        reg_read(8'h02, "R11 pointer loaded");
        reg_read(8'h40, "R11 logical0 source");
        reg_read(8'h82, "R11 logical2 target");

        // R7 freeze
        reg_write(8'h01, 64'h1);
        drive_branch(3'd6, 1'b0, 64'hA00, 64'hB00, 1'b0, 1'b0, 1'b0, 1'b1);
        check(XL'(frozen), 1, "R7 frozen after pmi");
        reg_read(8'h40, "R7 same-cycle branch recorded");
        drive_branch(3'd6, 1'b0, 64'hA10, 64'hB10, 1'b0, 1'b0, 1'b0, 1'b0);
        reg_read(8'h02, "R7 no record while frozen");
        reg_write(8'h01, 64'h3);
        check(XL'(frozen), 1, "R7 bit1 set keeps freeze");
        reg_write(8'h01, 64'h1);
        check(XL'(frozen), 0, "R7 cleared by software");
        drive_branch(3'd6, 1'b0, 64'hA20, 64'hB20, 1'b0, 1'b0, 1'b0, 1'b0);
        reg_read(8'h02, "R7 records after clear");

        // R6/R8 call-stack mode
        reg_write(8'h00, 64'h200);
        reg_write(8'h02, 64'h0);
        drive_branch(3'd5, 1'b0, 64'hC00, 64'hD00, 1'b0, 1'b0, 1'b0, 1'b1);
        check(XL'(frozen), 0, "R8 no freeze in call-stack mode");
        reg_read(8'h02, "R6 jump ignored");
        drive_branch(3'd1, 1'b0, 64'hC10, 64'hD10, 1'b0, 1'b0, 1'b0, 1'b0);
        drive_branch(3'd2, 1'b1, 64'hC20, 64'hD20, 1'b0, 1'b0, 1'b0, 1'b0);
        reg_read(8'h02, "R6 two pushes");
        drive_branch(3'd3, 1'b1, 64'hC30, 64'hD30, 1'b0, 1'b0, 1'b0, 1'b0);
        reg_read(8'h02, "R6 pop");
        reg_read(8'h40, "R6 top after pop");
        drive_branch(3'd3, 1'b0, 64'hC40, 64'hD40, 1'b0, 1'b0, 1'b0, 1'b0);
        drive_branch(3'd3, 1'b0, 64'hC50, 64'hD50, 1'b0, 1'b0, 1'b0, 1'b0);
        reg_read(8'h02, "R6 pop wraps below zero");

        repeat (3) @(negedge clk);
        check(XL'(exp_q.size()), 0, "R10 reads outstanding");
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule